// File: doc/BRIEF.md
# Power-Management Bus Command Channel Front End

This block gives software a set of command channels for a power-management serial bus. Each channel has its own register window on a simple memory-mapped bus. Software places a data byte in the channel's write-data register, then writes a packed command word. The word carries the operation, slave ID, peripheral ID, register offset and byte count. Software then polls the channel's status register until it is non-zero, and for reads it collects the byte from the read-data register.

Commands go out one at a time on a parallel request/response port toward a slave model. A single request is in flight at once. Channels waiting for the port are served lowest index first. A read-only table, placed in its own address region, tells software which slave and peripheral each channel serves. Every channel also has a configuration register, which is stored and can be read back but has no effect on behaviour.

Top module: `pmic_arb_front`

## Requirements
- R1: Bus address bit 23 clear selects channel space. Channel n's window starts at n*0x8000. Within a window the command register is at 0x0, configuration at 0x4, status at 0x8, write data at 0x10 and read data at 0x18. The write-data register keeps its low 8 bits. A bus read returns its data with `bus_rvalid` one clock after `bus_rd`.
- R2: The command word is decoded as opcode [31:27], slave ID [26:20], peripheral ID [19:12], register offset [11:4] and byte count [3:0]. Opcode 0 issues a write with `sl_we`=1 and the channel's write-data byte. Opcode 1 issues a read with `sl_we`=0. The slave ID, peripheral ID and offset are passed on unchanged.
- R3: Status reads 0 while a command is in flight and 0x1 after a successful response. After a successful read, the read-data register holds the returned byte in bits 7:0, with all upper bits zero.
- R4: An error response from the slave sets status to 0x2. That value stays until the next accepted command write to the channel, which clears it to 0.
- R5: A command with a byte count other than 1, an opcode above 1 or a slave ID of 16 or more sets status to 0x2 on the next clock. No slave request is made for it.
- R6: A command write to a channel whose command is still in flight is ignored. It does not change that command's status or read data, and it issues no extra request. This also holds when the write falls in the cycle of the response.
- R7: At most one slave request is outstanding. `sl_req` is a one-cycle pulse. When several channels are waiting, the lowest-numbered one is issued first. A response and a new command on another channel in the same cycle are both handled.
- R8: With bus address bit 23 set and bits 22:9 zero, word i (address offset 4*i, i < 128) reads the slave ID of channel i in bits 19:16 and its peripheral ID in bits 15:8. All other bits are zero, words for i >= NUM_CH read zero, and writes to this region change nothing.
- R9: The configuration register stores all 32 bits and reads them back. Its value does not alter how a command completes.
- R10: After reset every status reads 0, every read-data register reads 0 and no slave request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one clock after bus_rd |
| sl_req | output | 1 | Slave request pulse |
| sl_we | output | 1 | 1 = register write, 0 = register read |
| sl_sid | output | 4 | Slave ID |
| sl_pid | output | 8 | Peripheral ID |
| sl_off | output | 8 | Register offset |
| sl_wdata | output | 8 | Write byte |
| sl_rsp | input | 1 | Slave response pulse |
| sl_err | input | 1 | Response is an error (valid with sl_rsp) |
| sl_rdata | input | 8 | Read byte (valid with sl_rsp) |

## Verification
Two things can fall in the same cycle: the completion of the outstanding command (`sl_rsp`) and a software command write. The bench uses a manually driven slave and raises the response on the very clock that carries a command write. In one case the write goes to a different channel, and that channel must be issued next while the finished channel reads 0x1 with the right byte. In the other case the write goes to the channel that is completing, and it must be dropped: status becomes 0x1 and no second request appears.

// File: rtl/pmic_arb_pkg.sv
package pmic_arb_pkg;
  localparam int WIN_LG2 = 15;
  localparam int TBL_W   = 7;

  localparam logic [WIN_LG2-1:0] OFS_CMD  = 15'h0000;
  localparam logic [WIN_LG2-1:0] OFS_CFG  = 15'h0004;
  localparam logic [WIN_LG2-1:0] OFS_STAT = 15'h0008;
  localparam logic [WIN_LG2-1:0] OFS_WDAT = 15'h0010;
  localparam logic [WIN_LG2-1:0] OFS_RDAT = 15'h0018;

  localparam logic [1:0] ST_IDLE = 2'd0;
  localparam logic [1:0] ST_OK   = 2'd1;
  localparam logic [1:0] ST_FAIL = 2'd2;

  typedef struct packed {
    logic       we;
    logic [3:0] sid;
    logic [7:0] pid;
    logic [7:0] off;
    logic [7:0] data;
  } slv_req_t;
endpackage

// File: rtl/pmic_arb_chan.sv
module pmic_arb_chan
  import pmic_arb_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_wr,
  input  logic        cfg_wr,
  input  logic        wd_wr,
  input  logic [31:0] wdata,
  input  logic        grant,
  input  logic        done,
  input  logic        done_err,
  input  logic [7:0]  done_rdata,
  output logic        pending,
  output logic        busy,
  output logic [1:0]  status,
  output logic [31:0] cfg,
  output logic [7:0]  wbyte,
  output logic [7:0]  rbyte,
  output slv_req_t    req
);
  logic [4:0] opc;
  logic [6:0] sid_w;
  logic [3:0] cnt;
  logic       accept, legal;

  assign opc    = wdata[31:27];
  assign sid_w  = wdata[26:20];
  assign cnt    = wdata[3:0];
  assign accept = cmd_wr && !busy;
  assign legal  = (opc <= 5'd1) && (cnt == 4'd1) && (sid_w < 7'd16);

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      busy    <= 1'b0;
      status  <= ST_IDLE;
      cfg     <= '0;
      wbyte   <= '0;
      rbyte   <= '0;
      req     <= '0;
    end else begin
      if (cfg_wr) cfg <= wdata;
      if (wd_wr)  wbyte <= wdata[7:0];
      if (accept) begin
        req.we   <= (opc == 5'd0);
        req.sid  <= sid_w[3:0];
        req.pid  <= wdata[19:12];
        req.off  <= wdata[11:4];
        req.data <= wbyte;
        if (legal) begin
          busy    <= 1'b1;
          pending <= 1'b1;
          status  <= ST_IDLE;
        end else begin
          status  <= ST_FAIL;
        end
      end else begin
        if (grant) pending <= 1'b0;
        if (done) begin
          busy   <= 1'b0;
          status <= done_err ? ST_FAIL : ST_OK;
          if (!done_err && !req.we) rbyte <= done_rdata;
        end
      end
    end
  end
endmodule

// File: rtl/pmic_arb_issue.sv
module pmic_arb_issue
  import pmic_arb_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CHW    = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_CH-1:0]     pending,
  input  slv_req_t [NUM_CH-1:0] reqs,
  output logic [NUM_CH-1:0]     grant,
  output logic [NUM_CH-1:0]     done,
  output logic                  sl_req,
  output slv_req_t              sl_fields,
  input  logic                  sl_rsp
);
  logic           out_q;
  logic [CHW-1:0] act_q, pick;
  logic           any;

  always_comb begin
    any  = 1'b0;
    pick = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (pending[i]) begin
        any  = 1'b1;
        pick = CHW'(i);
      end
    end
    grant = '0;
    if (!out_q && any) grant[pick] = 1'b1;
    done = '0;
    if (out_q && sl_rsp) done[act_q] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q     <= 1'b0;
      act_q     <= '0;
      sl_req    <= 1'b0;
      sl_fields <= '0;
    end else begin
      sl_req <= 1'b0;
      if (!out_q && any) begin
        sl_req    <= 1'b1;
        out_q     <= 1'b1;
        act_q     <= pick;
        sl_fields <= reqs[pick];
      end else if (out_q && sl_rsp) begin
        out_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pmic_arb_map.sv
module pmic_arb_map
  import pmic_arb_pkg::*;
#(
  parameter int                  NUM_CH = 4,
  parameter logic [NUM_CH*12-1:0] CH_MAP = '0
) (
  input  logic [TBL_W-1:0] idx,
  output logic [31:0]      word
);
  always_comb begin
    word = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (idx == TBL_W'(i))
        word = {12'h000, CH_MAP[i*12+8 +: 4], CH_MAP[i*12 +: 8], 8'h00};
    end
  end
endmodule

// File: rtl/pmic_arb_front.sv
module pmic_arb_front
  import pmic_arb_pkg::*;
#(
  parameter int                   NUM_CH = 4,
  parameter int                   ADDR_W = 24,
  parameter logic [NUM_CH*12-1:0] CH_MAP = 48'h1200C20C10C0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  output logic              sl_req,
  output logic              sl_we,
  output logic [3:0]        sl_sid,
  output logic [7:0]        sl_pid,
  output logic [7:0]        sl_off,
  output logic [7:0]        sl_wdata,
  input  logic              sl_rsp,
  input  logic              sl_err,
  input  logic [7:0]        sl_rdata
);
  localparam int CHW   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int SEL_W = ADDR_W - 1 - WIN_LG2;

  logic               tbl_hit, ch_ok;
  logic [SEL_W-1:0]   chsel;
  logic [CHW-1:0]     chi;
  logic [WIN_LG2-1:0] ofs;
  logic [31:0]        map_word, rd_next;
  slv_req_t           fields;

  logic [NUM_CH-1:0]        cmd_wr_v, cfg_wr_v, wd_wr_v;
  logic [NUM_CH-1:0]        pend_v, busy_v, grant_v, done_v;
  logic [NUM_CH-1:0][1:0]   status_v;
  logic [NUM_CH-1:0][31:0]  cfg_v;
  logic [NUM_CH-1:0][7:0]   wbyte_v, rbyte_v;
  slv_req_t [NUM_CH-1:0]    req_v;

  assign tbl_hit = bus_addr[ADDR_W-1] && (bus_addr[ADDR_W-2:9] == '0);
  assign chsel   = bus_addr[ADDR_W-2:WIN_LG2];
  assign ch_ok   = !bus_addr[ADDR_W-1] && (int'(chsel) < NUM_CH);
  assign chi     = CHW'(chsel);
  assign ofs     = bus_addr[WIN_LG2-1:0];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    logic sel;
    assign sel         = bus_wr && ch_ok && (chi == CHW'(g));
    assign cmd_wr_v[g] = sel && (ofs == OFS_CMD);
    assign cfg_wr_v[g] = sel && (ofs == OFS_CFG);
    assign wd_wr_v[g]  = sel && (ofs == OFS_WDAT);

    pmic_arb_chan u_chan (
      .clk        (clk),
      .rst        (rst),
      .cmd_wr     (cmd_wr_v[g]),
      .cfg_wr     (cfg_wr_v[g]),
      .wd_wr      (wd_wr_v[g]),
      .wdata      (bus_wdata),
      .grant      (grant_v[g]),
      .done       (done_v[g]),
      .done_err   (sl_err),
      .done_rdata (sl_rdata),
      .pending    (pend_v[g]),
      .busy       (busy_v[g]),
      .status     (status_v[g]),
      .cfg        (cfg_v[g]),
      .wbyte      (wbyte_v[g]),
      .rbyte      (rbyte_v[g]),
      .req        (req_v[g])
    );
  end

  pmic_arb_issue #(.NUM_CH(NUM_CH), .CHW(CHW)) u_issue (
    .clk       (clk),
    .rst       (rst),
    .pending   (pend_v),
    .reqs      (req_v),
    .grant     (grant_v),
    .done      (done_v),
    .sl_req    (sl_req),
    .sl_fields (fields),
    .sl_rsp    (sl_rsp)
  );

  pmic_arb_map #(.NUM_CH(NUM_CH), .CH_MAP(CH_MAP)) u_map (
    .idx  (bus_addr[TBL_W+1:2]),
    .word (map_word)
  );

  assign sl_we    = fields.we;
  assign sl_sid   = fields.sid;
  assign sl_pid   = fields.pid;
  assign sl_off   = fields.off;
  assign sl_wdata = fields.data;

  always_comb begin
    rd_next = '0;
    if (tbl_hit) begin
      rd_next = map_word;
    end else if (ch_ok) begin
      case (ofs)
        OFS_CFG:  rd_next = cfg_v[chi];
        OFS_STAT: rd_next = {30'd0, status_v[chi]};
        OFS_WDAT: rd_next = {24'd0, wbyte_v[chi]};
        OFS_RDAT: rd_next = {24'd0, rbyte_v[chi]};
        default:  rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_next;
    end
  end
endmodule

// File: rtl/pmic_arb_chk.sv
module pmic_arb_chk #(
  parameter int NUM_CH = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   bus_rd,
  input logic                   bus_rvalid,
  input logic                   sl_req,
  input logic                   sl_rsp,
  input logic [NUM_CH-1:0]      busy,
  input logic [NUM_CH-1:0][1:0] status,
  input logic [NUM_CH-1:0]      cmd_wr
);
  logic out_q;

  always_ff @(posedge clk) begin
    if (rst) out_q <= 1'b0;
    else if (sl_req) out_q <= 1'b1;
    else if (sl_rsp) out_q <= 1'b0;
  end

  assert_one_outstanding_R7: assert property (@(posedge clk) disable iff (rst)
    out_q |-> !sl_req);

  assert_req_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    sl_req |=> !sl_req);

  assert_rvalid_follows_R1: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);

  assert_rvalid_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> !bus_rvalid);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    assert_busy_reads_zero_R3: assert property (@(posedge clk) disable iff (rst)
      busy[i] |-> (status[i] == 2'd0));

    assert_fail_holds_R4: assert property (@(posedge clk) disable iff (rst)
      ((status[i] == 2'd2) && !cmd_wr[i]) |=> (status[i] == 2'd2));
  end
endmodule

bind pmic_arb_front pmic_arb_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_rd     (bus_rd),
  .bus_rvalid (bus_rvalid),
  .sl_req     (sl_req),
  .sl_rsp     (sl_rsp),
  .busy       (busy_v),
  .status     (status_v),
  .cmd_wr     (cmd_wr_v)
);

// File: tb/tb_pmic_arb_front.sv
module tb_pmic_arb_front;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [23:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        sl_req, sl_we, sl_rsp, sl_err;
  logic [3:0]  sl_sid;
  logic [7:0]  sl_pid, sl_off, sl_wdata, sl_rdata;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  pmic_arb_front dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .sl_req(sl_req), .sl_we(sl_we), .sl_sid(sl_sid), .sl_pid(sl_pid),
    .sl_off(sl_off), .sl_wdata(sl_wdata), .sl_rsp(sl_rsp), .sl_err(sl_err),
    .sl_rdata(sl_rdata)
  );

  // slave model
  logic       manual = 1'b0, man_rsp = 1'b0, man_err = 1'b0;
  logic [7:0] man_rd = '0;
  logic       a_rsp, a_err;
  logic [7:0] a_rd;
  int         lat, req_cnt;
  logic       cap_we;
  logic [3:0] cap_sid;
  logic [7:0] cap_pid, cap_off, cap_data;

  function automatic logic [7:0] model(input logic [3:0] s, input logic [7:0] p, input logic [7:0] o);
    return p ^ o ^ {s, s};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      lat <= 0; a_rsp <= 1'b0; a_err <= 1'b0; a_rd <= '0; req_cnt <= 0;
      cap_we <= 1'b0; cap_sid <= '0; cap_pid <= '0; cap_off <= '0; cap_data <= '0;
    end else begin
      a_rsp <= 1'b0;
      if (sl_req) begin
        req_cnt <= req_cnt + 1;
        cap_we <= sl_we; cap_sid <= sl_sid; cap_pid <= sl_pid;
        cap_off <= sl_off; cap_data <= sl_wdata;
        if (!manual) lat <= 3;
      end else if (lat > 0) begin
        lat <= lat - 1;
        if (lat == 1) begin
          a_rsp <= 1'b1;
          a_err <= (cap_off == 8'hEE);
          a_rd  <= model(cap_sid, cap_pid, cap_off);
        end
      end
    end
  end

  assign sl_rsp   = a_rsp | man_rsp;
  assign sl_err   = a_rsp ? a_err : man_err;
  assign sl_rdata = a_rsp ? a_rd : man_rd;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] ca(input int ch, input int ofs);
    return 24'(ch * 32'h8000 + ofs);
  endfunction

  task automatic bwrite(input logic [23:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bread(input logic [23:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
    chk(bus_rvalid === 1'b1, "R1 rvalid", {31'd0, bus_rvalid}, 32'd1);
  endtask

  task automatic poll(input int ch, output logic [31:0] st);
    int n = 0;
    st = '0;
    while (st == 0 && n < 60) begin
      bread(ca(ch, 8), st);
      n++;
    end
  endtask

  task automatic wait_req(input int target);
    int n = 0;
    while (req_cnt < target && n < 40) begin
      @(negedge clk);
      n++;
    end
    chk(req_cnt == target, "R7 request seen", 32'(req_cnt), 32'(target));
  endtask

  task automatic respond(input logic e, input logic [7:0] d);
    @(negedge clk);
    man_rsp = 1'b1; man_err = e; man_rd = d;
    @(negedge clk);
    man_rsp = 1'b0;
  endtask

  task automatic respond_and_write(input logic [7:0] d, input logic [23:0] a, input logic [31:0] w);
    @(negedge clk);
    man_rsp = 1'b1; man_err = 1'b0; man_rd = d;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = w;
    @(negedge clk);
    man_rsp = 1'b0; bus_wr = 1'b0;
  endtask

  typedef struct packed {
    logic [1:0]  ch;
    logic [31:0] cmd;
    logic [7:0]  wd;
    logic [1:0]  st;
    logic        early;
  } vec_t;

  // command = {opcode[4:0], sid[6:0], pid[7:0], off[7:0], count[3:0]}
  localparam vec_t VECS [10] = '{
    '{2'd0, {5'd0, 7'd0,  8'hC0, 8'h40, 4'd1}, 8'h5A, 2'd1, 1'b0},
    '{2'd1, {5'd1, 7'd3,  8'h07, 8'h12, 4'd1}, 8'h00, 2'd1, 1'b0},
    '{2'd2, {5'd0, 7'd15, 8'hFF, 8'h01, 4'd1}, 8'hA5, 2'd1, 1'b0},
    '{2'd3, {5'd1, 7'd0,  8'hC3, 8'hEE, 4'd1}, 8'h00, 2'd2, 1'b0},
    '{2'd0, {5'd0, 7'd0,  8'hC0, 8'h41, 4'd2}, 8'h11, 2'd2, 1'b1},
    '{2'd1, {5'd3, 7'd0,  8'h10, 8'h00, 4'd1}, 8'h00, 2'd2, 1'b1},
    '{2'd2, {5'd1, 7'd9,  8'h80, 8'h7F, 4'd1}, 8'h00, 2'd1, 1'b0},
    '{2'd3, {5'd0, 7'd16, 8'h00, 8'h00, 4'd1}, 8'h00, 2'd2, 1'b1},
    '{2'd1, {5'd0, 7'd2,  8'h33, 8'hEE, 4'd1}, 8'h77, 2'd2, 1'b0},
    '{2'd0, {5'd1, 7'd0,  8'h00, 8'h00, 4'd0}, 8'h00, 2'd2, 1'b1}
  };

  function automatic logic [31:0] mk(input logic [4:0] op, input logic [7:0] pid);
    return {op, 7'd0, pid, 8'h10, 4'd1};
  endfunction

  bit finished = 1'b0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int base;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R10 reset state
    for (int c = 0; c < 4; c++) begin
      bread(ca(c, 8), d);
      chk(d == 0, "R10 status after reset", d, 0);
      bread(ca(c, 24), d);
      chk(d == 0, "R10 rdata after reset", d, 0);
    end
    chk(req_cnt == 0, "R10 no request after reset", 32'(req_cnt), 0);

    // R8 channel table
    bread(24'h800000, d); chk(d == 32'h0000C000, "R8 table word 0", d, 32'h0000C000);
    bread(24'h800004, d); chk(d == 32'h0000C100, "R8 table word 1", d, 32'h0000C100);
    bread(24'h800008, d); chk(d == 32'h0000C200, "R8 table word 2", d, 32'h0000C200);
    bread(24'h80000C, d); chk(d == 32'h00012000, "R8 table word 3", d, 32'h00012000);
    bread(24'h800010, d); chk(d == 32'h0, "R8 table word 4 empty", d, 0);
    bread(24'h8001FC, d); chk(d == 32'h0, "R8 table word 127 empty", d, 0);
    bwrite(24'h800000, 32'hFFFFFFFF);
    bread(24'h800000, d); chk(d == 32'h0000C000, "R8 table write ignored", d, 32'h0000C000);

    // R9 config stored, no effect
    bwrite(ca(2, 4), 32'hDEAD0001);
    bread(ca(2, 4), d); chk(d == 32'hDEAD0001, "R9 config readback", d, 32'hDEAD0001);

    // vector table
    for (int v = 0; v < 10; v++) begin
      vec_t t;
      t = VECS[v];
      base = req_cnt;
      bwrite(ca(t.ch, 16), {24'hFFFFFF, t.wd});
      bread(ca(t.ch, 16), d);
      chk(d == {24'd0, t.wd}, "R1 write-data register", d, {24'd0, t.wd});
      bwrite(ca(t.ch, 0), t.cmd);
      bread(ca(t.ch, 8), d);
      if (t.early) begin
        chk(d == 2, "R5 illegal command fails at once", d, 2);
        repeat (6) @(negedge clk);
        chk(req_cnt == base, "R5 no slave request", 32'(req_cnt), 32'(base));
      end else begin
        chk(d == 0, "R3 status zero in flight", d, 0);
        poll(t.ch, d);
        chk(d == {30'd0, t.st}, t.st == 2 ? "R4 slave error status" : "R3 success status", d, {30'd0, t.st});
        chk({cap_we, cap_sid, cap_pid, cap_off} == {t.cmd[31:27] == 5'd0, t.cmd[23:20], t.cmd[19:12], t.cmd[11:4]},
            "R2 slave fields", {11'd0, cap_we, cap_sid, cap_pid, cap_off},
            {11'd0, t.cmd[31:27] == 5'd0, t.cmd[23:20], t.cmd[19:12], t.cmd[11:4]});
        if (t.cmd[31:27] == 5'd0)
          chk(cap_data == t.wd, "R2 write byte", {24'd0, cap_data}, {24'd0, t.wd});
        else if (t.st == 1) begin
          bread(ca(t.ch, 24), d);
          chk(d == {24'd0, model(t.cmd[23:20], t.cmd[19:12], t.cmd[11:4])}, "R3 read data",
              d, {24'd0, model(t.cmd[23:20], t.cmd[19:12], t.cmd[11:4])});
        end
      end
    end

    // R4 fail holds, cleared by next command
    repeat (10) @(negedge clk);
    bread(ca(1, 8), d); chk(d == 2, "R4 fail status held", d, 2);
    manual = 1'b1;
    base = req_cnt;
    bwrite(ca(1, 0), mk(5'd1, 8'h44));
    bread(ca(1, 8), d); chk(d == 0, "R4 cleared by new command", d, 0);
    wait_req(base + 1);

    // R6 write while busy ignored
    bwrite(ca(1, 0), mk(5'd0, 8'h55));
    bread(ca(1, 8), d); chk(d == 0, "R6 busy status unchanged", d, 0);
    respond(1'b0, 8'h77);
    bread(ca(1, 8), d); chk(d == 1, "R6 original command completes", d, 1);
    bread(ca(1, 24), d); chk(d == 32'h77, "R6 original read data", d, 32'h77);
    repeat (5) @(negedge clk);
    chk(req_cnt == base + 1, "R6 no extra request", 32'(req_cnt), 32'(base + 1));

    // R7 lowest index first
    base = req_cnt;
    bwrite(ca(3, 0), mk(5'd1, 8'h03));
    wait_req(base + 1);
    chk(cap_pid == 8'h03, "R7 first request", {24'd0, cap_pid}, 32'h03);
    bwrite(ca(2, 0), mk(5'd1, 8'h02));
    bwrite(ca(1, 0), mk(5'd1, 8'h01));
    respond(1'b0, 8'h30);
    wait_req(base + 2);
    chk(cap_pid == 8'h01, "R7 lowest channel next", {24'd0, cap_pid}, 32'h01);
    respond(1'b0, 8'h10);
    wait_req(base + 3);
    chk(cap_pid == 8'h02, "R7 remaining channel last", {24'd0, cap_pid}, 32'h02);
    respond(1'b0, 8'h20);
    bread(ca(2, 24), d); chk(d == 32'h20, "R7 channel 2 data", d, 32'h20);
    bread(ca(3, 24), d); chk(d == 32'h30, "R7 channel 3 data", d, 32'h30);

    // collision: response and command on another channel in one cycle
    base = req_cnt;
    bwrite(ca(0, 0), mk(5'd1, 8'hA0));
    wait_req(base + 1);
    respond_and_write(8'h3C, ca(1, 0), mk(5'd1, 8'hA1));
    wait_req(base + 2);
    chk(cap_pid == 8'hA1, "R7 collision other channel issued", {24'd0, cap_pid}, 32'hA1);
    bread(ca(0, 8), d);  chk(d == 1, "R7 collision finished status", d, 1);
    bread(ca(0, 24), d); chk(d == 32'h3C, "R3 collision read data", d, 32'h3C);
    respond(1'b0, 8'h4D);
    bread(ca(1, 8), d);  chk(d == 1, "R7 collision second completes", d, 1);

    // collision: response and command on the same channel
    base = req_cnt;
    bwrite(ca(0, 0), mk(5'd1, 8'hB0));
    wait_req(base + 1);
    respond_and_write(8'h5E, ca(0, 0), mk(5'd1, 8'hB1));
    repeat (6) @(negedge clk);
    chk(req_cnt == base + 1, "R6 same-cycle write ignored", 32'(req_cnt), 32'(base + 1));
    bread(ca(0, 8), d);  chk(d == 1, "R6 same-cycle status", d, 1);
    bread(ca(0, 24), d); chk(d == 32'h5E, "R6 same-cycle data", d, 32'h5E);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule